// File: doc/BRIEF.md
# DiSEqC Tone-Gating Message Transmitter

This block drives a single enable line that switches an external 22 kHz oscillator on and off, so that a satellite switch or LNB on the coax sees DiSEqC messages and mini-command tone bursts. A free-running tick generator divides the system clock down to a timebase of about 500 us (2001 cycles of a 4 MHz clock by default; the divider is a parameter). Every transmitted bit occupies three ticks. The length of the tone inside those three ticks carries the bit value.

A transfer begins with a one-cycle start strobe, which carries a message length and a burst-select level. The block silences the carrier and waits a settling period. It then does one of three things. If the length is non-zero, it pulls message bytes one at a time through a valid/ready byte port and sends each byte as eight data bits followed by a parity bit. If the length is zero and burst-select is low, it sends a plain tone burst. If the length is zero and burst-select is high, it sends an all-ones byte. A one-cycle done pulse marks the end of a transfer. If the byte source cannot supply a byte when one is needed, the transfer is cut short and the done pulse is accompanied by an underrun pulse.

Top module: `dsq_tone_tx`

## Requirements
- R1: After reset, `tone_en_o`, `busy_o`, `done_o`, `underrun_o` and `byte_ready_o` are all low.
- R2: A start accepted at clock edge 0 restarts the tick phase, so that ticks fall on edges k*TICK_DIV. The carrier stays off through a settling wait of 15 ticks, ending at edge 15*TICK_DIV. The tick phase is restarted again there, at the start of the first byte.
- R3: Bit j of a message uses the three ticks that follow edge (15+3j)*TICK_DIV. The carrier is off through the first of those ticks, turns on at the first tick edge and stays on for one tick for a '1' or two ticks for a '0'. It is always off after the third tick edge.
- R4: Each byte is sent most significant bit first. The ninth bit is a parity bit, which is '1' when the data byte holds an even number of ones, so that the nine bits together have odd parity.
- R5: With a non-zero length, `byte_ready_o` is high for exactly the one cycle before each byte's first tick edge. A byte is taken on that edge when `byte_valid_i` is also high. `burst_sel_i` has no effect in this case.
- R6: With a zero length and `burst_sel_i` low, the carrier turns on at edge 16*TICK_DIV and off at edge 41*TICK_DIV, which is 25 ticks of tone. `byte_ready_o` stays low throughout.
- R7: With a zero length and `burst_sel_i` high, the block sends the byte 0xFF with its parity bit ('1') using the timing of R3, and never raises `byte_ready_o`.
- R8: `done_o` is a one-cycle pulse, high in the cycle after the edge that follows the final carrier-off tick edge F. `busy_o` is high from the cycle after the start edge until that same done cycle.
- R9: A start strobe while `busy_o` is high is ignored, and the transfer in progress continues unchanged.
- R10: If `byte_valid_i` is low when a byte is needed, no further tone is produced. The transfer ends at that tick edge, and `underrun_o` pulses together with `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to begin a transfer; ignored while busy |
| nbytes_i | input | LEN_W | Number of message bytes, sampled with start |
| burst_sel_i | input | 1 | With zero length: low selects the plain tone burst, high selects the all-ones byte |
| byte_valid_i | input | 1 | Byte source has a byte on `byte_data_i` |
| byte_data_i | input | 8 | Next message byte |
| byte_ready_o | output | 1 | Block takes a byte on this edge if valid is high |
| tone_en_o | output | 1 | Gate for the external 22 kHz oscillator |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| underrun_o | output | 1 | One-cycle pulse with done when the transfer was cut short by a missing byte |

## Verification
All timing is expressed as edge counts from the edge that samples start. The carrier state after edge n is expected from the tick count floor((n-16*D)/(3*D)) and the remainder within the symbol. The done and underrun pulses are due in the cycle after edge F+1, where F is (15+27*bytes_sent)*D, or 41*D for the plain burst. The bench samples every output on the falling edge after each rising edge, compares the carrier against this formula in every cycle up to three cycles past done, and counts handshakes by noting ready and valid at one falling edge and crediting the transfer at the following one.

// File: rtl/dsq_pkg.sv
package dsq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SETTLE,
    S_SYM,
    S_GAP,
    S_TONE,
    S_FIN
  } seq_state_t;

  localparam logic [7:0] ALL_ONES_BYTE = 8'hFF;

  // running parity: accumulates XOR of data bits shifted out so far
  function automatic logic parity_next(input logic acc, input logic data_bit);
    return acc ^ data_bit;
  endfunction

  // parity symbol: '1' when the data byte held an even number of ones
  function automatic logic parity_symbol(input logic acc);
    return ~acc;
  endfunction

  // after the second tick of a symbol the carrier is cut when the bit is '1'
  function automatic logic cut_after_second_tick(input logic sym_bit);
    return sym_bit;
  endfunction

endpackage

// File: rtl/dsq_tick_gen.sv
module dsq_tick_gen #(
  parameter int DIV = 2001
) (
  input  logic clk,
  input  logic rst_n,
  input  logic resync_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (resync_i || tick_o) cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dsq_bit_ser.sv
module dsq_bit_ser
  import dsq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  logic [7:0] data_i,
  input  logic       adv_i,
  output logic       bit_o,
  output logic       last_o
);
  logic [7:0] sh_q;
  logic [3:0] idx_q;
  logic       par_q;

  assign last_o = (idx_q == 4'd8);
  assign bit_o  = last_o ? parity_symbol(par_q) : sh_q[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      idx_q <= '0;
      par_q <= 1'b0;
    end else if (load_i) begin
      sh_q  <= data_i;
      idx_q <= '0;
      par_q <= 1'b0;
    end else if (adv_i) begin
      par_q <= parity_next(par_q, sh_q[7]);
      sh_q  <= {sh_q[6:0], 1'b0};
      idx_q <= idx_q + 4'd1;
    end
  end
endmodule

// File: rtl/dsq_seq_ctrl.sv
module dsq_seq_ctrl
  import dsq_pkg::*;
#(
  parameter int SETTLE_TICKS = 15,
  parameter int BURST_TICKS  = 25,
  parameter int LEN_W        = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic [LEN_W-1:0] nbytes_i,
  input  logic             burst_sel_i,
  input  logic             byte_valid_i,
  input  logic             ser_bit_i,
  input  logic             ser_last_i,
  output logic             resync_o,
  output logic             ser_load_o,
  output logic             ser_adv_o,
  output logic             ser_use_pattern_o,
  output logic             byte_ready_o,
  output logic             tone_en_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             underrun_o
);
  localparam int TMAX = (SETTLE_TICKS > BURST_TICKS) ? SETTLE_TICKS : BURST_TICKS;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] SETTLE_LAST = TW'(SETTLE_TICKS - 1);
  localparam logic [TW-1:0] BURST_LAST  = TW'(BURST_TICKS - 1);

  seq_state_t       state_q;
  logic [TW-1:0]    tcnt_q;
  logic [1:0]       phase_q;
  logic [LEN_W-1:0] left_q;
  logic             sel_q;
  logic             err_q;
  logic             tone_q;
  logic             done_q;
  logic             und_q;

  logic start_acc, settle_end, sym_end, need_byte, take, pattern_load;

  assign start_acc    = (state_q == S_IDLE) && start_i;
  assign settle_end   = (state_q == S_SETTLE) && tick_i && (tcnt_q == SETTLE_LAST);
  assign sym_end      = (state_q == S_SYM) && tick_i && (phase_q == 2'd2) && ser_last_i;
  assign need_byte    = (settle_end || sym_end) && (left_q != '0);
  assign take         = need_byte && byte_valid_i;
  assign pattern_load = settle_end && (left_q == '0) && sel_q;

  assign byte_ready_o      = need_byte;
  assign ser_load_o        = take || pattern_load;
  assign ser_use_pattern_o = pattern_load;
  assign ser_adv_o         = (state_q == S_SYM) && tick_i && (phase_q == 2'd2) && !ser_last_i;
  assign resync_o          = start_acc || settle_end;
  assign busy_o            = (state_q != S_IDLE);
  assign tone_en_o         = tone_q;
  assign done_o            = done_q;
  assign underrun_o        = und_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      tcnt_q  <= '0;
      phase_q <= '0;
      left_q  <= '0;
      sel_q   <= 1'b0;
      err_q   <= 1'b0;
      tone_q  <= 1'b0;
      done_q  <= 1'b0;
      und_q   <= 1'b0;
    end else begin
      done_q <= (state_q == S_FIN);
      und_q  <= (state_q == S_FIN) && err_q;
      case (state_q)
        S_IDLE: begin
          if (start_i) begin
            state_q <= S_SETTLE;
            tcnt_q  <= '0;
            left_q  <= nbytes_i;
            sel_q   <= burst_sel_i;
            err_q   <= 1'b0;
            tone_q  <= 1'b0;
          end
        end
        S_SETTLE: begin
          if (tick_i) begin
            if (tcnt_q == SETTLE_LAST) begin
              phase_q <= '0;
              if (left_q != '0) begin
                if (byte_valid_i) begin
                  left_q  <= left_q - 1'b1;
                  state_q <= S_SYM;
                end else begin
                  err_q   <= 1'b1;
                  state_q <= S_FIN;
                end
              end else if (sel_q) begin
                state_q <= S_SYM;
              end else begin
                state_q <= S_GAP;
              end
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
        end
        S_SYM: begin
          if (tick_i) begin
            case (phase_q)
              2'd0: begin
                tone_q  <= 1'b1;
                phase_q <= 2'd1;
              end
              2'd1: begin
                if (cut_after_second_tick(ser_bit_i)) tone_q <= 1'b0;
                phase_q <= 2'd2;
              end
              default: begin
                tone_q  <= 1'b0;
                phase_q <= 2'd0;
                if (ser_last_i) begin
                  if (left_q != '0) begin
                    if (byte_valid_i) begin
                      left_q <= left_q - 1'b1;
                    end else begin
                      err_q   <= 1'b1;
                      state_q <= S_FIN;
                    end
                  end else begin
                    state_q <= S_FIN;
                  end
                end
              end
            endcase
          end
        end
        S_GAP: begin
          if (tick_i) begin
            tone_q  <= 1'b1;
            tcnt_q  <= '0;
            state_q <= S_TONE;
          end
        end
        S_TONE: begin
          if (tick_i) begin
            if (tcnt_q == BURST_LAST) begin
              tone_q  <= 1'b0;
              state_q <= S_FIN;
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dsq_tone_tx.sv
module dsq_tone_tx
  import dsq_pkg::*;
#(
  parameter int TICK_DIV     = 2001,
  parameter int SETTLE_TICKS = 15,
  parameter int BURST_TICKS  = 25,
  parameter int LEN_W        = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LEN_W-1:0] nbytes_i,
  input  logic             burst_sel_i,
  input  logic             byte_valid_i,
  input  logic [7:0]       byte_data_i,
  output logic             byte_ready_o,
  output logic             tone_en_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             underrun_o
);
  // named internal events, visible to the bound checker
  logic       tick_w;
  logic       resync_w;
  logic       ser_load_w;
  logic       ser_adv_w;
  logic       ser_pat_w;
  logic       ser_bit_w;
  logic       ser_last_w;
  logic [7:0] ser_data_w;

  assign ser_data_w = ser_pat_w ? ALL_ONES_BYTE : byte_data_i;

  dsq_tick_gen #(.DIV(TICK_DIV)) tick_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .resync_i (resync_w),
    .tick_o   (tick_w)
  );

  dsq_bit_ser ser_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (ser_load_w),
    .data_i (ser_data_w),
    .adv_i  (ser_adv_w),
    .bit_o  (ser_bit_w),
    .last_o (ser_last_w)
  );

  dsq_seq_ctrl #(
    .SETTLE_TICKS (SETTLE_TICKS),
    .BURST_TICKS  (BURST_TICKS),
    .LEN_W        (LEN_W)
  ) seq_i (
    .clk               (clk),
    .rst_n             (rst_n),
    .tick_i            (tick_w),
    .start_i           (start_i),
    .nbytes_i          (nbytes_i),
    .burst_sel_i       (burst_sel_i),
    .byte_valid_i      (byte_valid_i),
    .ser_bit_i         (ser_bit_w),
    .ser_last_i        (ser_last_w),
    .resync_o          (resync_w),
    .ser_load_o        (ser_load_w),
    .ser_adv_o         (ser_adv_w),
    .ser_use_pattern_o (ser_pat_w),
    .byte_ready_o      (byte_ready_o),
    .tone_en_o         (tone_en_o),
    .busy_o            (busy_o),
    .done_o            (done_o),
    .underrun_o        (underrun_o)
  );
endmodule

// File: rtl/dsq_tone_tx_chk.sv
module dsq_tone_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic tick_w,
  input logic byte_valid_i,
  input logic byte_ready_o,
  input logic tone_en_o,
  input logic busy_o,
  input logic done_o,
  input logic underrun_o
);
  assert_ready_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ready_o |-> tick_w);

  assert_take_keeps_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_ready_o && byte_valid_i) |=> busy_o);

  assert_tone_rise_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tone_en_o) |-> $past(tick_w));

  assert_tone_fall_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tone_en_o) |-> $past(tick_w));

  assert_idle_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !tone_en_o);

  assert_start_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> !tone_en_o);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  assert_underrun_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_o |-> done_o);

  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && tone_en_o && start_i) |=> busy_o);
endmodule

bind dsq_tone_tx dsq_tone_tx_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .tick_w       (tick_w),
  .byte_valid_i (byte_valid_i),
  .byte_ready_o (byte_ready_o),
  .tone_en_o    (tone_en_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .underrun_o   (underrun_o)
);

// File: tb/dsq_tone_tx_tb_top.sv
module dsq_tone_tx_tb_top;
  localparam int D     = 5;
  localparam int LEN_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [LEN_W-1:0] nbytes_i = '0;
  logic             burst_sel_i = 1'b0;
  logic             byte_valid_i = 1'b0;
  logic [7:0]       byte_data_i = '0;
  logic             byte_ready_o, tone_en_o, busy_o, done_o, underrun_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  dsq_tone_tx #(.TICK_DIV(D), .LEN_W(LEN_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .nbytes_i(nbytes_i),
    .burst_sel_i(burst_sel_i), .byte_valid_i(byte_valid_i), .byte_data_i(byte_data_i),
    .byte_ready_o(byte_ready_o), .tone_en_o(tone_en_o), .busy_o(busy_o),
    .done_o(done_o), .underrun_o(underrun_o)
  );

  // {restart, nbytes, burst_sel, bytes_available, seed}
  localparam int NV = 7;
  localparam logic [17:0] VEC [NV] = '{
    {1'b0, 4'd1, 1'b0, 4'd1, 8'hA5},
    {1'b1, 4'd3, 1'b0, 4'd3, 8'h00},
    {1'b0, 4'd2, 1'b1, 4'd2, 8'hFF},
    {1'b0, 4'd0, 1'b0, 4'd0, 8'h00},
    {1'b0, 4'd0, 1'b1, 4'd0, 8'h00},
    {1'b0, 4'd3, 1'b0, 4'd1, 8'h5C},
    {1'b0, 4'd2, 1'b0, 4'd0, 8'h11}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] gen_byte(input logic [7:0] seed, input int k);
    return seed ^ 8'(k * 59);
  endfunction

  // symbol k of the message: byte k/9, position k%9 (8 = parity)
  function automatic bit sym_bit(input bit pat, input logic [7:0] seed, input int k);
    logic [7:0] b;
    int pos;
    b   = pat ? 8'hFF : gen_byte(seed, k / 9);
    pos = k % 9;
    if (pos < 8) return b[7 - pos];
    return ($countones(b) % 2) == 0;
  endfunction

  task automatic run_msg(input int nb, input bit sel, input int avail,
                         input logic [7:0] seed, input bit restart);
    bit   burst_a, burst_b, und, pend, exp_tone;
    int   sent, end_e, idx, xfers, wave_bad, first_n, done_bad, und_bad, busy_bad;
    string wtag;
    burst_a = (nb == 0) && !sel;
    burst_b = (nb == 0) && sel;
    und     = (nb > 0) && (avail < nb);
    sent    = burst_b ? 1 : (nb == 0 ? 0 : (und ? avail : nb));
    end_e   = burst_a ? 41 * D : (15 + 27 * sent) * D;
    wtag    = burst_a ? "R2/R6 burst A" : (burst_b ? "R2/R7 burst B" :
              (restart ? "R9 restart ignored" : "R2/R3/R4 message"));
    idx = 0; xfers = 0; wave_bad = 0; first_n = -1;
    done_bad = 0; und_bad = 0; busy_bad = 0; pend = 1'b0;
    @(negedge clk);
    nbytes_i     = LEN_W'(nb);
    burst_sel_i  = sel;
    start_i      = 1'b1;
    byte_valid_i = (idx < avail);
    byte_data_i  = gen_byte(seed, idx);
    for (int n = 0; n <= end_e + 3; n++) begin
      @(negedge clk);
      if (n == 0) start_i = 1'b0;
      if (restart && n == 100) begin
        start_i = 1'b1; nbytes_i = '0; burst_sel_i = 1'b0;
      end
      if (restart && n == 101) start_i = 1'b0;
      if (pend) begin
        idx++; xfers++;
        byte_valid_i = (idx < avail);
        byte_data_i  = gen_byte(seed, idx);
      end
      if (burst_a) begin
        exp_tone = (n >= 16 * D) && (n < 41 * D);
      end else begin
        int p, j, r;
        p = n - 16 * D;
        exp_tone = 1'b0;
        if (p >= 0) begin
          j = p / (3 * D);
          r = p % (3 * D);
          if (j < 9 * sent) exp_tone = (r < (sym_bit(burst_b, seed, j) ? D : 2 * D));
        end
      end
      if (tone_en_o !== exp_tone) begin
        wave_bad++;
        if (first_n < 0) first_n = n;
      end
      if (done_o !== (n == end_e + 1)) done_bad++;
      if (underrun_o !== (und && n == end_e + 1)) und_bad++;
      if (busy_o !== (n <= end_e)) busy_bad++;
      pend = byte_ready_o && byte_valid_i;
    end
    byte_valid_i = 1'b0;
    chk(wave_bad == 0, {wtag, " carrier waveform (first bad cycle as actual)"}, first_n, -1);
    chk(done_bad == 0, "R8 done pulse timing", done_bad, 0);
    chk(busy_bad == 0, "R8 busy window", busy_bad, 0);
    chk(und_bad == 0, "R10 underrun pulse", und_bad, 0);
    chk(xfers == (burst_b ? 0 : sent), burst_b ? "R7 no byte requests" : "R5 bytes taken",
        xfers, burst_b ? 0 : sent);
  endtask

  initial begin
    #(100000 * 10);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: state held in reset and just after release
    chk(!tone_en_o && !busy_o && !done_o && !underrun_o && !byte_ready_o,
        "R1 outputs in reset", {tone_en_o, busy_o, done_o, underrun_o, byte_ready_o}, 0);
    rst_n = 1'b1;
    repeat (2 * D) @(negedge clk);
    chk(!tone_en_o && !busy_o && !done_o && !underrun_o && !byte_ready_o,
        "R1 outputs after reset", {tone_en_o, busy_o, done_o, underrun_o, byte_ready_o}, 0);

    for (int v = 0; v < NV; v++) begin
      run_msg(int'(VEC[v][16:13]), VEC[v][12], int'(VEC[v][11:8]), VEC[v][7:0], VEC[v][17]);
      repeat (3) @(negedge clk);
    end

    // R10 corner: underrun leaves the carrier silent afterwards
    repeat (4 * D) @(negedge clk);
    chk(!tone_en_o && !busy_o, "R10 silent after underrun", {tone_en_o, busy_o}, 0);

    // R1: a mid-transfer reset returns every output to idle
    @(negedge clk);
    nbytes_i = 8'd1; burst_sel_i = 1'b0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (20 * D) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!tone_en_o && !busy_o && !done_o && !byte_ready_o,
        "R1 outputs after mid-transfer reset", {tone_en_o, busy_o, done_o, byte_ready_o}, 0);
    rst_n = 1'b1;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule